// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. It opens an input gate so an external integrator charges for a fixed window. It then reads the comparator to find which way the charge went, and switches in the reference of opposite sign. After a short settling wait it counts clock cycles until the comparator flips back. The count is the magnitude of the input. The comparator polarity seen at the end of the window supplies the sign.

After every conversion, an auto-zero window lets the analog side null the comparator path and recharge its stored reference. A conversion starts on a pulse of `start`. While `cont` is high, conversions follow one another with no idle gap. The integrator, comparator, switches and references are outside the block. To the block the comparator is a single asynchronous bit.

Top module: `dslope_seq`

## Requirements
- R1: After a conversion begins, `int_en` is high for exactly INT_CYC consecutive cycles, then falls. The default is CLK_HZ/10 cycles, which is 100 ms.
- R2: `cmp_in` passes through a two-flop synchronizer. The synchronized level in the cycle where integration ends is captured as the polarity. A high comparator means a positive input.
- R3: A captured high level selects `ref_neg_en`. A captured low level selects `ref_pos_en`. The selected enable rises in the same cycle that `int_en` falls and stays high through settling and counting. The two enables are never high together.
- R4: Counting starts only after a settle window of DLY_CYC cycles, which by default is 15 µs. The magnitude is the number of counted cycles during which the synchronized comparator still equals the captured level. Take a comparator change driven n cycles after the reference enable rises: it gives a magnitude of max(0, n+2-DLY_CYC).
- R5: If the comparator has not changed after MAX_CYC counted cycles, counting ends. `result_ovr` is then 1 and `result_mag` equals MAX_CYC. Otherwise `result_ovr` is 0.
- R6: In the cycle after the count stops, `az_en` rises. It stays high for exactly AZ_CYC cycles. Both reference enables and `int_en` are low during this window.
- R7: `result_valid` is a one-cycle pulse. It coincides with the update of `result_mag`, `result_sign` and `result_ovr`. `result_sign` is 1 for a negative input, that is, a captured low level.
- R8: A `start` pulse while idle begins one conversion. With `cont` low, the block goes idle after auto-zero and asserts no enable until the next start.
- R9: While `cont` is high, `int_en` rises in the same cycle that `az_en` falls, with no idle cycle between them.
- R10: A synchronous active-high `rst` returns the block to idle. It forces all four enables and `result_valid` low, even in the middle of a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one conversion when idle |
| cont | input | 1 | Repeat conversions back to back |
| cmp_in | input | 1 | Asynchronous comparator level |
| int_en | output | 1 | Input integrate gate |
| ref_pos_en | output | 1 | Positive reference switch (negative input) |
| ref_neg_en | output | 1 | Negative reference switch (positive input) |
| az_en | output | 1 | Auto-zero switch |
| result_valid | output | 1 | One-cycle result strobe |
| result_sign | output | 1 | 1 = negative input |
| result_mag | output | $clog2(MAX_CYC+1) | Counted magnitude |
| result_ovr | output | 1 | Count hit MAX_CYC without a comparator change |

## Verification
The bench overrides the timing parameters: INT_CYC=20, DLY_CYC=4, AZ_CYC=5 and MAX_CYC=30. With these values a full conversion lasts about sixty cycles. This makes reachable several cases that the real-time defaults would take far too long to produce: both polarities, a comparator change during settling (magnitude 0), a magnitude one below the limit, and the overrange limit itself. The short windows also allow several back-to-back continuous conversions and a reset in the middle of integration within a short run.

// File: rtl/dslope_pkg.sv
`timescale 1ns/1ps
package dslope_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_INTEG  = 3'd1,
    PH_SETTLE = 3'd2,
    PH_DEINT  = 3'd3,
    PH_AZERO  = 3'd4
  } phase_e;
endpackage

// File: rtl/dslope_sync.sv
`timescale 1ns/1ps
module dslope_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/dslope_fsm.sv
`timescale 1ns/1ps
module dslope_fsm
  import dslope_pkg::*;
#(
  parameter int INT_CYC = 20,
  parameter int DLY_CYC = 4,
  parameter int AZ_CYC  = 5,
  parameter int MAX_CYC = 30,
  parameter int TW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cont,
  input  logic          cmp_s,
  output phase_e        st,
  output logic [TW-1:0] tmr,
  output logic          pol_q,
  output logic          stop_hit,
  output logic          ovr_hit,
  output logic          int_en,
  output logic          ref_pos_en,
  output logic          ref_neg_en,
  output logic          az_en
);
  phase_e nxt;
  logic   pol_d;
  logic   ref_on;

  always_comb begin
    nxt      = st;
    stop_hit = 1'b0;
    ovr_hit  = 1'b0;
    case (st)
      PH_IDLE:   if (start || cont) nxt = PH_INTEG;
      PH_INTEG:  if (tmr == TW'(INT_CYC - 1)) nxt = PH_SETTLE;
      PH_SETTLE: if (tmr == TW'(DLY_CYC - 1)) nxt = PH_DEINT;
      PH_DEINT: begin
        if (cmp_s != pol_q) begin
          stop_hit = 1'b1;
          nxt      = PH_AZERO;
        end else if (tmr == TW'(MAX_CYC - 1)) begin
          ovr_hit  = 1'b1;
          nxt      = PH_AZERO;
        end
      end
      PH_AZERO:  if (tmr == TW'(AZ_CYC - 1)) nxt = cont ? PH_INTEG : PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
  end

  // polarity that the next reference choice must follow
  assign pol_d  = (st == PH_INTEG) ? cmp_s : pol_q;
  assign ref_on = (nxt == PH_SETTLE) || (nxt == PH_DEINT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_IDLE;
      tmr        <= '0;
      pol_q      <= 1'b0;
      int_en     <= 1'b0;
      ref_pos_en <= 1'b0;
      ref_neg_en <= 1'b0;
      az_en      <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st || st == PH_IDLE) tmr <= '0;
      else                            tmr <= tmr + 1'b1;
      if (st == PH_INTEG && nxt == PH_SETTLE) pol_q <= cmp_s;
      int_en     <= (nxt == PH_INTEG);
      ref_neg_en <= ref_on && pol_d;
      ref_pos_en <= ref_on && !pol_d;
      az_en      <= (nxt == PH_AZERO);
    end
  end

  // R3
  ref_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ref_pos_en && ref_neg_en));
  // R1
  int_len_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_INTEG) |-> (tmr < TW'(INT_CYC)));
  // R3
  int_ref_chk: assert property (@(posedge clk) disable iff (rst)
    int_en |-> !(ref_pos_en || ref_neg_en));
  // R4
  deint_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_DEINT) |-> (ref_pos_en || ref_neg_en));
  // R5
  max_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_DEINT) |-> (tmr < TW'(MAX_CYC)));
  // R6
  az_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    az_en |-> !(int_en || ref_pos_en || ref_neg_en));
  // R3
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_neg_en && $past(ref_neg_en)) |-> $stable(pol_q));
endmodule

// File: rtl/dslope_result.sv
`timescale 1ns/1ps
module dslope_result #(
  parameter int MAX_CYC = 30,
  parameter int TW      = 8,
  parameter int MW      = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stop_hit,
  input  logic          ovr_hit,
  input  logic          pol_q,
  input  logic [TW-1:0] tmr,
  output logic          result_valid,
  output logic          result_sign,
  output logic [MW-1:0] result_mag,
  output logic          result_ovr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result_valid <= 1'b0;
      result_sign  <= 1'b0;
      result_mag   <= '0;
      result_ovr   <= 1'b0;
    end else begin
      result_valid <= stop_hit || ovr_hit;
      if (stop_hit || ovr_hit) begin
        result_sign <= !pol_q;
        result_ovr  <= ovr_hit;
        result_mag  <= ovr_hit ? MW'(MAX_CYC) : MW'(tmr);
      end
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);
  // R5
  ovr_mag_chk: assert property (@(posedge clk) disable iff (rst)
    (result_valid && result_ovr) |-> (result_mag == MW'(MAX_CYC)));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!result_valid && !$past(rst)) |-> ($stable(result_mag) && $stable(result_sign)));
endmodule

// File: rtl/dslope_seq.sv
`timescale 1ns/1ps
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int CLK_HZ  = 1_000_000,
  parameter int INT_CYC = CLK_HZ / 10,
  parameter int DLY_CYC = int'((64'(CLK_HZ) * 64'd15) / 64'd1_000_000),
  parameter int AZ_CYC  = CLK_HZ / 10,
  parameter int MAX_CYC = 2 * INT_CYC,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         cont,
  input  logic                         cmp_in,
  output logic                         int_en,
  output logic                         ref_pos_en,
  output logic                         ref_neg_en,
  output logic                         az_en,
  output logic                         result_valid,
  output logic                         result_sign,
  output logic [$clog2(MAX_CYC+1)-1:0] result_mag,
  output logic                         result_ovr
);
  localparam int MW   = $clog2(MAX_CYC + 1);
  localparam int BIG1 = (INT_CYC > DLY_CYC) ? INT_CYC : DLY_CYC;
  localparam int BIG2 = (AZ_CYC > MAX_CYC) ? AZ_CYC : MAX_CYC;
  localparam int BIG  = (BIG1 > BIG2) ? BIG1 : BIG2;
  localparam int TW   = $clog2(BIG + 1);

  logic          cmp_s;
  phase_e        st;
  logic [TW-1:0] tmr;
  logic          pol_q;
  logic          stop_hit;
  logic          ovr_hit;

  dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_in),
    .q   (cmp_s)
  );

  dslope_fsm #(
    .INT_CYC (INT_CYC),
    .DLY_CYC (DLY_CYC),
    .AZ_CYC  (AZ_CYC),
    .MAX_CYC (MAX_CYC),
    .TW      (TW)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cont       (cont),
    .cmp_s      (cmp_s),
    .st         (st),
    .tmr        (tmr),
    .pol_q      (pol_q),
    .stop_hit   (stop_hit),
    .ovr_hit    (ovr_hit),
    .int_en     (int_en),
    .ref_pos_en (ref_pos_en),
    .ref_neg_en (ref_neg_en),
    .az_en      (az_en)
  );

  dslope_result #(
    .MAX_CYC (MAX_CYC),
    .TW      (TW),
    .MW      (MW)
  ) u_res (
    .clk          (clk),
    .rst          (rst),
    .stop_hit     (stop_hit),
    .ovr_hit      (ovr_hit),
    .pol_q        (pol_q),
    .tmr          (tmr),
    .result_valid (result_valid),
    .result_sign  (result_sign),
    .result_mag   (result_mag),
    .result_ovr   (result_ovr)
  );

  // R9
  back2back_chk: assert property (@(posedge clk) disable iff (rst)
    (cont && $fell(az_en)) |-> int_en);
endmodule

// File: tb/dslope_seq_test.sv
`timescale 1ns/1ps
module dslope_seq_test;
  localparam int INT_CYC = 20;
  localparam int DLY_CYC = 4;
  localparam int AZ_CYC  = 5;
  localparam int MAX_CYC = 30;
  localparam int MW      = $clog2(MAX_CYC + 1);

  // {level, n (255 = never change), expected mag, expected ovr}
  localparam logic [15:0] VECS [0:7] = '{
    {1'b1, 8'd10,  6'd8,  1'b0},
    {1'b0, 8'd10,  6'd8,  1'b0},
    {1'b1, 8'd0,   6'd0,  1'b0},
    {1'b0, 8'd2,   6'd0,  1'b0},
    {1'b1, 8'd3,   6'd1,  1'b0},
    {1'b0, 8'd31,  6'd29, 1'b0},
    {1'b1, 8'd32,  6'd30, 1'b1},
    {1'b0, 8'd255, 6'd30, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cont = 1'b0;
  logic cmp_in = 1'b0;
  logic int_en, ref_pos_en, ref_neg_en, az_en;
  logic result_valid, result_sign, result_ovr;
  logic [MW-1:0] result_mag;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  dslope_seq #(
    .CLK_HZ  (250_000_000),
    .INT_CYC (INT_CYC),
    .DLY_CYC (DLY_CYC),
    .AZ_CYC  (AZ_CYC),
    .MAX_CYC (MAX_CYC)
  ) uut (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .cont         (cont),
    .cmp_in       (cmp_in),
    .int_en       (int_en),
    .ref_pos_en   (ref_pos_en),
    .ref_neg_en   (ref_neg_en),
    .az_en        (az_en),
    .result_valid (result_valid),
    .result_sign  (result_sign),
    .result_mag   (result_mag),
    .result_ovr   (result_ovr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic run_conv(input logic lvl, input int n, input int em, input logic eo);
    int cnt;
    int guard;
    @(negedge clk);
    cmp_in = lvl;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    cnt = 0;
    while (int_en && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == INT_CYC, "R1 integrate length", cnt, INT_CYC);
    check(ref_neg_en == lvl && ref_pos_en == !lvl, "R2/R3 reference choice",
          {ref_neg_en, ref_pos_en}, {lvl, !lvl});
    if (n < 200) begin
      for (int k = 0; k < n; k++) @(negedge clk);
      cmp_in = !lvl;
    end
    guard = 0;
    while (!result_valid && guard < 200) begin
      guard++;
      @(negedge clk);
    end
    check(result_valid, "R7 valid strobe", result_valid, 1);
    check(int'(result_mag) == em, "R4 magnitude", result_mag, em);
    check(result_ovr == eo, "R5 overrange flag", result_ovr, eo);
    check(result_sign == !lvl, "R7 sign", result_sign, !lvl);
    check(az_en && !ref_pos_en && !ref_neg_en && !int_en, "R6 auto-zero entry",
          {az_en, ref_pos_en, ref_neg_en, int_en}, 8);
    cnt = 0;
    while (az_en && cnt < 1000) begin
      cnt++;
      @(negedge clk);
      check(!result_valid || cnt > 1, "R7 single pulse", result_valid, 0);
    end
    check(cnt == AZ_CYC, "R6 auto-zero length", cnt, AZ_CYC);
    repeat (4) @(negedge clk);
    check(!int_en && !az_en && !ref_pos_en && !ref_neg_en, "R8 stays idle",
          {int_en, az_en, ref_pos_en, ref_neg_en}, 0);
  endtask

  initial begin
    int vals;
    int falls;
    repeat (3) @(negedge clk);
    check(!int_en && !ref_pos_en && !ref_neg_en && !az_en && !result_valid,
          "R10 reset state", {int_en, ref_pos_en, ref_neg_en, az_en, result_valid}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!int_en, "R8 no start no conversion", int_en, 0);

    foreach (VECS[i]) begin
      run_conv(VECS[i][15], int'(VECS[i][14:7]), int'(VECS[i][6:1]), VECS[i][0]);
    end

    // R9 continuous mode: comparator never changes, so every conversion overranges
    @(negedge clk);
    cmp_in = 1'b1;
    cont   = 1'b1;
    vals = 0;
    falls = 0;
    for (int k = 0; k < 140; k++) begin
      logic az_was;
      az_was = az_en;
      @(negedge clk);
      if (result_valid) begin
        vals++;
        check(result_ovr && int'(result_mag) == MAX_CYC, "R9 continuous result",
              result_mag, MAX_CYC);
      end
      if (az_was && !az_en) begin
        falls++;
        check(int_en, "R9 back-to-back integrate", int_en, 1);
      end
    end
    check(vals >= 2, "R9 repeated conversions", vals, 2);
    check(falls >= 2, "R9 auto-zero ends", falls, 2);
    cont = 1'b0;
    repeat (80) @(negedge clk);
    check(!int_en && !az_en, "R8 idle after cont drops", {int_en, az_en}, 0);

    // R10 reset in the middle of integration
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    check(int_en, "R1 integrating before reset", int_en, 1);
    rst = 1'b1;
    @(negedge clk);
    check(!int_en && !ref_pos_en && !ref_neg_en && !az_en && !result_valid,
          "R10 mid-conversion reset", {int_en, ref_pos_en, ref_neg_en, az_en}, 0);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    check(!int_en && !ref_pos_en && !ref_neg_en, "R10 idle after reset",
          {int_en, ref_pos_en, ref_neg_en}, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule